// File: doc/BRIEF.md
# Touch-Panel Digitizer Command Sequencer

This block is the digital controller of a four-wire resistive touch-panel digitizer. A two-wire serial slave port in front of it handles addressing and line conditioning. It hands this block a frame-start strobe, a one-cycle strobe for each serial-clock rising edge, the data bit for that edge, and a flag that marks master-acknowledge clocks. The block shifts in an 8-bit command and decodes the channel, resolution and power fields. It switches the panel driver enables and the sense multiplexer, then runs a successive-approximation conversion with the same serial clock. Each conversion clock tests one bit of a trial code against a 1-bit comparator input.

The result comes back as two bytes. The upper byte carries the eight most significant result bits. The lower byte carries the remaining bits left-aligned, with zeros below them. When the block rests powered down, the Y- driver grounds its plate and the X+ sense line is pulled up. A pen touch then pulls the sense line low, which drives the active-low pen interrupt. The interrupt is masked from the start of a command frame until the block goes back to the powered-down idle state.

Top module: `touchAdcSeq`

## Requirements
- R1: After reset the block rests powered down. `drvYn`=1, `pullUpEn`=1, the other three driver enables are 0, `busy`=0, `dataValid`=0, both result bytes are 0 and `muxSel`=0.
- R2: The command is sampled MSB first, one bit per `sclRise` pulse after `frameStart`. Bit 7 is the start bit, bits 6:4 the channel, bit 3 the resolution (1 = 8-bit) and bit 2 the keep-powered flag. Bits 1:0 are ignored.
- R3: A command whose start bit is 0 starts no conversion. The block goes back to the idle state it was in before the frame: powered down, or powered with the previous channel's drivers on.
- R4: During a conversion `muxSel` equals the channel field. Channel 101 enables X+ and X-, and channel 001 enables Y+ and Y-. Channels 011 and 100 enable Y+ and X-. Every other channel enables no driver.
- R5: A 12-bit conversion takes 12 counted clocks and resolves one bit per clock, MSB first. `dacTrial` shows the bits decided so far plus the bit under test. The bit is kept when `cmpIn` is 1. With a comparator that reports trial <= V, the result equals V.
- R6: A `sclRise` pulse with `masterAck` high during a conversion is not counted and decides no bit.
- R7: `hiByte` = result[11:4] and `loByte` = {result[3:0], 4'b0000}. `dataValid` is 1 at the first sample after the last counted clock, and it is cleared when a new frame starts.
- R8: In 8-bit mode the conversion takes 8 counted clocks. `hiByte` = V[11:4] and `loByte` = 0.
- R9: After a conversion with keep-powered = 0, the block goes back to the powered-down configuration of R1. With keep-powered = 1, the channel's drivers stay on and `pullUpEn` = 0.
- R10: `penIrqN` follows `penSenseN` only in the powered-down idle state. At all other times, including command shifting and conversion, it is 1.
- R11: A `frameStart` during a conversion abandons it. The new command is then processed normally, and its result is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle strobe opening a command frame |
| sclRise | input | 1 | One-cycle strobe per serial-clock rising edge |
| sdaIn | input | 1 | Serial data bit for the current `sclRise` |
| masterAck | input | 1 | Marks an `sclRise` as a master-acknowledge clock |
| cmpIn | input | 1 | Comparator decision: 1 when the input is at or above `dacTrial` |
| penSenseN | input | 1 | X+ sense level, low when the pen touches |
| dacTrial | output | 12 | Trial code for the capacitor DAC |
| muxSel | output | 3 | Sense multiplexer select (latched channel) |
| drvXp | output | 1 | X+ driver enable |
| drvXn | output | 1 | X- driver enable |
| drvYp | output | 1 | Y+ driver enable |
| drvYn | output | 1 | Y- driver enable |
| pullUpEn | output | 1 | Weak pull-up on the X+ sense line |
| busy | output | 1 | Conversion in progress |
| dataValid | output | 1 | Result bytes hold a finished conversion |
| hiByte | output | 8 | Result bits 11:4 |
| loByte | output | 8 | Result bits 3:0, left-aligned, zero-filled |
| penIrqN | output | 1 | Active-low pen interrupt |

## Verification
Two pairs of events can fall in the same system cycle. A serial clock can arrive while the acknowledge flag is high in the middle of a conversion, and a new frame can start while a conversion step or a pen touch is pending. The bench places acknowledge clocks before the first, a middle and the last conversion clock. It judges them by the result still matching the comparator's target value and by the block staying busy for the extra clock. A frame opened mid-conversion, with the pen held down, is judged by `dataValid` dropping, by `penIrqN` staying high and by the second command's target being the one reported.

// File: rtl/tpSeqPkg.sv
package tpSeqPkg;
  localparam int CMD_W     = 8;
  localparam int POS_START = 7;
  localparam int POS_CHAN  = 4;   // lsb of the channel field
  localparam int CHAN_W    = 3;
  localparam int POS_MODE  = 3;
  localparam int POS_KEEP  = 2;

  localparam logic [CHAN_W-1:0] CH_Y  = 3'b001;
  localparam logic [CHAN_W-1:0] CH_Z1 = 3'b011;
  localparam logic [CHAN_W-1:0] CH_Z2 = 3'b100;
  localparam logic [CHAN_W-1:0] CH_X  = 3'b101;

  typedef struct packed {
    logic clrCmd;
    logic shiftCmd;
    logic loadCmd;
    logic sarStep;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/tpSeqCtrl.sv
module tpSeqCtrl
  import tpSeqPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int LOW_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             sclRise,
  input  logic             masterAck,
  input  logic [CMD_W-1:0] cmdWord,
  output seqStrobe_t       strobe,
  output logic             busy,
  output logic             panelOn,
  output logic             penArmed
);
  localparam int STEP_W = $clog2(RES_BITS + 1);
  localparam int CNT_W  = $clog2(CMD_W);

  typedef enum logic [1:0] {ST_PD, ST_ON, ST_CMD, ST_CONV} state_t;

  state_t            state;
  logic [CNT_W-1:0]  bitCnt;
  logic [STEP_W-1:0] stepsLeft;
  logic              wasOn;
  logic              keepOn;
  logic              lastCmdBit;

  assign lastCmdBit = (bitCnt == CNT_W'(CMD_W - 1));

  always_comb begin
    strobe          = '0;
    strobe.clrCmd   = frameStart;
    strobe.shiftCmd = (state == ST_CMD) && sclRise && !frameStart;
    strobe.loadCmd  = strobe.shiftCmd && lastCmdBit && cmdWord[POS_START];
    strobe.sarStep  = (state == ST_CONV) && sclRise && !masterAck && !frameStart;
    strobe.finish   = strobe.sarStep && (stepsLeft == STEP_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PD;
      bitCnt    <= '0;
      stepsLeft <= '0;
      wasOn     <= 1'b0;
      keepOn    <= 1'b0;
    end else if (frameStart) begin
      state  <= ST_CMD;
      bitCnt <= '0;
      wasOn  <= (state == ST_ON) || ((state == ST_CMD) && wasOn)
                || ((state == ST_CONV) && keepOn);
    end else if (strobe.shiftCmd) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastCmdBit) begin
        if (cmdWord[POS_START]) begin
          state     <= ST_CONV;
          keepOn    <= cmdWord[POS_KEEP];
          stepsLeft <= cmdWord[POS_MODE] ? STEP_W'(LOW_BITS) : STEP_W'(RES_BITS);
        end else begin
          state <= wasOn ? ST_ON : ST_PD;
        end
      end
    end else if (strobe.sarStep) begin
      stepsLeft <= stepsLeft - 1'b1;
      if (strobe.finish) state <= keepOn ? ST_ON : ST_PD;
    end
  end

  assign busy     = (state == ST_CONV);
  assign panelOn  = (state == ST_CONV) || (state == ST_ON);
  assign penArmed = (state == ST_PD);

  AST_ACK_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclRise && masterAck && !frameStart) |=> $stable(stepsLeft)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepsLeft != '0 && stepsLeft <= STEP_W'(RES_BITS))); // R5
  AST_BAD_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftCmd && lastCmdBit && !cmdWord[POS_START]) |=> !busy); // R3
endmodule

// File: rtl/tpSeqData.sv
module tpSeqData
  import tpSeqPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                sdaIn,
  input  logic                cmpIn,
  input  logic                busy,
  input  logic                panelOn,
  output logic [CMD_W-1:0]    cmdWord,
  output logic [RES_BITS-1:0] dacTrial,
  output logic [CHAN_W-1:0]   chanSel,
  output logic [BYTE_W-1:0]   hiByte,
  output logic [BYTE_W-1:0]   loByte,
  output logic                dataValid,
  output logic                drvXp,
  output logic                drvXn,
  output logic                drvYp,
  output logic                drvYn,
  output logic                pullUpEn
);
  localparam int LOW_W = RES_BITS - BYTE_W;
  localparam int PAD_W = BYTE_W - LOW_W;

  logic [CMD_W-1:0]    cmdShift;
  logic [RES_BITS-1:0] approx;
  logic [RES_BITS-1:0] ptr;
  logic [RES_BITS-1:0] approxNext;
  logic                lowResReg;

  assign cmdWord    = {cmdShift[CMD_W-2:0], sdaIn};
  assign approxNext = cmpIn ? (approx | ptr) : approx;
  assign dacTrial   = busy ? (approx | ptr) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift  <= '0;
      chanSel   <= '0;
      lowResReg <= 1'b0;
      approx    <= '0;
      ptr       <= '0;
      hiByte    <= '0;
      loByte    <= '0;
      dataValid <= 1'b0;
    end else begin
      if (strobe.clrCmd) begin
        cmdShift  <= '0;
        dataValid <= 1'b0;
        ptr       <= '0;
      end
      if (strobe.shiftCmd) cmdShift <= cmdWord;
      if (strobe.loadCmd) begin
        chanSel   <= cmdWord[POS_CHAN +: CHAN_W];
        lowResReg <= cmdWord[POS_MODE];
        approx    <= '0;
        ptr       <= {1'b1, {(RES_BITS-1){1'b0}}};
      end
      if (strobe.sarStep) begin
        approx <= approxNext;
        ptr    <= ptr >> 1;
      end
      if (strobe.finish) begin
        hiByte    <= approxNext[RES_BITS-1 -: BYTE_W];
        loByte    <= {approxNext[LOW_W-1:0], {PAD_W{1'b0}}};
        dataValid <= 1'b1;
      end
    end
  end

  always_comb begin
    {drvXp, drvXn, drvYp} = 3'b000;
    drvYn    = 1'b1;
    pullUpEn = 1'b1;
    if (panelOn) begin
      drvYn    = 1'b0;
      pullUpEn = 1'b0;
      case (chanSel)
        CH_X:         {drvXp, drvXn} = 2'b11;
        CH_Y:         {drvYp, drvYn} = 2'b11;
        CH_Z1, CH_Z2: {drvYp, drvXn} = 2'b11;
        default:      ;
      endcase
    end
  end

  AST_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ptr)); // R5
  AST_LOW_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && lowResReg) |-> (loByte == '0)); // R8
  AST_DRIVER_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $countones({drvXp, drvXn, drvYp, drvYn}) <= 2); // R4
  AST_VALID_AFTER_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(busy)); // R7
endmodule

// File: rtl/touchAdcSeq.sv
module touchAdcSeq
  import tpSeqPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                sclRise,
  input  logic                sdaIn,
  input  logic                masterAck,
  input  logic                cmpIn,
  input  logic                penSenseN,
  output logic [RES_BITS-1:0] dacTrial,
  output logic [CHAN_W-1:0]   muxSel,
  output logic                drvXp,
  output logic                drvXn,
  output logic                drvYp,
  output logic                drvYn,
  output logic                pullUpEn,
  output logic                busy,
  output logic                dataValid,
  output logic [BYTE_W-1:0]   hiByte,
  output logic [BYTE_W-1:0]   loByte,
  output logic                penIrqN
);
  seqStrobe_t       strobe;
  logic [CMD_W-1:0] cmdWord;
  logic             panelOn;
  logic             penArmed;

  tpSeqCtrl #(.RES_BITS(RES_BITS), .LOW_BITS(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .sclRise(sclRise),
    .masterAck(masterAck), .cmdWord(cmdWord), .strobe(strobe),
    .busy(busy), .panelOn(panelOn), .penArmed(penArmed)
  );

  tpSeqData #(.RES_BITS(RES_BITS), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaIn(sdaIn), .cmpIn(cmpIn),
    .busy(busy), .panelOn(panelOn), .cmdWord(cmdWord), .dacTrial(dacTrial),
    .chanSel(muxSel), .hiByte(hiByte), .loByte(loByte), .dataValid(dataValid),
    .drvXp(drvXp), .drvXn(drvXn), .drvYp(drvYp), .drvYn(drvYn),
    .pullUpEn(pullUpEn)
  );

  assign penIrqN = penArmed ? penSenseN : 1'b1;

  AST_PEN_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> penIrqN); // R10
  AST_PEN_QUIET_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    (!pullUpEn) |-> penIrqN); // R10
endmodule

// File: tb/touchAdcSeq_test.sv
module touchAdcSeq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        sclRise = 1'b0;
  logic        sdaIn = 1'b0;
  logic        masterAck = 1'b0;
  logic        penSenseN = 1'b1;
  logic [11:0] target = '0;
  logic        cmpIn;
  logic [11:0] dacTrial;
  logic [2:0]  muxSel;
  logic        drvXp, drvXn, drvYp, drvYn, pullUpEn, busy, dataValid, penIrqN;
  logic [7:0]  hiByte, loByte;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  touchAdcSeq uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .sclRise(sclRise),
    .sdaIn(sdaIn), .masterAck(masterAck), .cmpIn(cmpIn), .penSenseN(penSenseN),
    .dacTrial(dacTrial), .muxSel(muxSel), .drvXp(drvXp), .drvXn(drvXn),
    .drvYp(drvYp), .drvYn(drvYn), .pullUpEn(pullUpEn), .busy(busy),
    .dataValid(dataValid), .hiByte(hiByte), .loByte(loByte), .penIrqN(penIrqN)
  );

  // behavioural comparator: keep the trial bit while trial <= panel level
  assign cmpIn = (dacTrial <= target);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expDrv(input logic [2:0] ch);
    case (ch)
      3'b101:         return 4'b1100;
      3'b001:         return 4'b0011;
      3'b011, 3'b100: return 4'b0110;
      default:        return 4'b0000;
    endcase
  endfunction

  task automatic pulseScl(input logic bitVal, input logic ack);
    @(negedge clk); sdaIn = bitVal; masterAck = ack; sclRise = 1'b1;
    @(negedge clk); sclRise = 1'b0; masterAck = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] cmd);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    for (int i = 7; i >= 0; i--) pulseScl(cmd[i], 1'b0);
  endtask

  task automatic runConv(input logic [2:0] ch, input logic lowRes, input logic keep,
                         input logic [11:0] tgt, input int ackStep);
    int steps;
    logic [7:0] expLo;
    target = tgt;
    steps = lowRes ? 8 : 12;
    sendCmd({1'b1, ch, lowRes, keep, 2'b10});   // R2: bits 1:0 are don't-care
    check(busy == 1'b1, "R2 busy after command", busy, 1);
    check({drvXp, drvXn, drvYp, drvYn} == expDrv(ch), "R4 drivers",
          {drvXp, drvXn, drvYp, drvYn}, expDrv(ch));
    check(muxSel == ch, "R4 muxSel", muxSel, ch);
    check(penIrqN == 1'b1, "R10 pen masked in conversion", penIrqN, 1);
    for (int s = 0; s < steps; s++) begin
      if (s == ackStep) begin
        pulseScl(1'b0, 1'b1);
        check(busy == 1'b1, "R6 ack clock not counted", busy, 1);
      end
      pulseScl(1'b0, 1'b0);
      if (s == 0) check(dacTrial == 12'h400 || dacTrial == 12'hC00 || busy == 1'b0,
                        "R5 second trial code", dacTrial, {tgt[11], 1'b1, 10'b0});
    end
    expLo = lowRes ? 8'h00 : {tgt[3:0], 4'b0000};
    check(dataValid == 1'b1, "R7 dataValid after last clock", dataValid, 1);
    check(hiByte == tgt[11:4], lowRes ? "R8 hiByte" : "R5 hiByte", hiByte, tgt[11:4]);
    check(loByte == expLo, lowRes ? "R8 loByte" : "R7 loByte", loByte, expLo);
    check(busy == 1'b0, "R5 conversion length", busy, 0);
    if (keep) begin
      check({drvXp, drvXn, drvYp, drvYn, pullUpEn} == {expDrv(ch), 1'b0},
            "R9 stays powered", {drvXp, drvXn, drvYp, drvYn, pullUpEn}, {expDrv(ch), 1'b0});
    end else begin
      check({drvXp, drvXn, drvYp, drvYn, pullUpEn} == 5'b00011,
            "R9 back to power-down", {drvXp, drvXn, drvYp, drvYn, pullUpEn}, 5'b00011);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    penSenseN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({drvXp, drvXn, drvYp, drvYn, pullUpEn} == 5'b00011, "R1 drivers",
          {drvXp, drvXn, drvYp, drvYn, pullUpEn}, 5'b00011);
    check(busy == 0 && dataValid == 0, "R1 busy/valid", {busy, dataValid}, 0);
    check(hiByte == 0 && loByte == 0 && muxSel == 0, "R1 bytes/mux",
          {hiByte, loByte, 5'(muxSel)}, 0);
    check(penIrqN == 1'b0, "R10 pen armed in power-down", penIrqN, 0);
    penSenseN = 1'b1;
    @(negedge clk);
    check(penIrqN == 1'b1, "R10 pen released", penIrqN, 1);

    // sweep: every channel, both power modes, 12-bit and 8-bit
    for (int t = 0; t < 4096; t += 41)
      runConv(3'(t % 8), 1'b0, 1'((t / 8) % 2), 12'(t), -1);
    for (int t = 7; t < 4096; t += 97)
      runConv(3'(t % 8), 1'b1, 1'(t % 2), 12'(t), -1);
    runConv(3'b101, 1'b0, 1'b0, 12'd4095, -1);
    runConv(3'b001, 1'b0, 1'b0, 12'd0, -1);
    runConv(3'b011, 1'b0, 1'b0, 12'd2048, -1);
    runConv(3'b100, 1'b0, 1'b0, 12'd2047, -1);
    runConv(3'b101, 1'b1, 1'b0, 12'd4095, -1);

    // R6 acknowledge clocks at first, middle and last step
    runConv(3'b101, 1'b0, 1'b0, 12'd2731, 0);
    runConv(3'b001, 1'b0, 1'b0, 12'd1365, 6);
    runConv(3'b011, 1'b0, 1'b0, 12'd3001, 11);
    runConv(3'b100, 1'b1, 1'b0, 12'd1234, 7);

    // R3 bad start bit from power-down
    sendCmd(8'h5C);
    check(busy == 1'b0, "R3 no conversion", busy, 0);
    check({drvXp, drvXn, drvYp, drvYn} == 4'b0001, "R3 stays powered down",
          {drvXp, drvXn, drvYp, drvYn}, 4'b0001);
    check(dataValid == 1'b0, "R7 cleared by frame", dataValid, 0);
    // R3 bad start bit from powered idle
    runConv(3'b101, 1'b0, 1'b1, 12'd100, -1);
    sendCmd(8'h1C);
    check(busy == 1'b0, "R3 no conversion when powered", busy, 0);
    check({drvXp, drvXn, drvYp, drvYn} == 4'b1100, "R3 back to powered idle",
          {drvXp, drvXn, drvYp, drvYn}, 4'b1100);
    check(muxSel == 3'b101, "R3 channel kept", muxSel, 3'b101);

    // R10 pen masked while powered, armed after return to power-down
    penSenseN = 1'b0;
    @(negedge clk);
    check(penIrqN == 1'b1, "R10 masked in powered idle", penIrqN, 1);
    runConv(3'b001, 1'b0, 1'b0, 12'd777, -1);
    check(penIrqN == 1'b0, "R10 re-armed", penIrqN, 0);

    // R11 abort mid-conversion with the pen held down
    target = 12'd3333;
    sendCmd(8'hD4);
    for (int s = 0; s < 5; s++) pulseScl(1'b0, 1'b0);
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    check(penIrqN == 1'b1, "R11 pen masked during new frame", penIrqN, 1);
    check(dataValid == 1'b0 && busy == 1'b0, "R11 abandoned", {busy, dataValid}, 0);
    for (int i = 7; i >= 0; i--) pulseScl(8'h90 >> i, 1'b0);
    target = 12'd555;
    for (int s = 0; s < 12; s++) pulseScl(1'b0, 1'b0);
    check(dataValid == 1'b1 && {hiByte, loByte} == {12'd555, 4'b0}, "R11 new result",
          {hiByte, loByte}, {12'd555, 4'b0});
    check(penIrqN == 1'b0, "R10 armed after abort run", penIrqN, 0);
    penSenseN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule